// File: doc/BRIEF.md
# Speculative Region Abort Controller

This block watches the head of the reorder buffer while a speculative region is open and runs the rollback when the region has to be abandoned. A region-start strobe records a shadow checkpoint: the address of the instruction after the start, and the stack pointer. It also sets the zero flag. From then on, an abort is raised only by the oldest reorder-buffer entry, never by a younger one. That entry must be valid and carry a capacity, conflict, explicit-abort or prohibited-operation flag. An abort is also raised by an immediate conflict interrupt or by an exception/interrupt request. Because only the oldest entry is checked, a flagged instruction on a mispredicted path is flushed by branch recovery before it can abort the region.

Once an abort is accepted, a fixed sequence of one-cycle steps runs: pipeline flush, status announcement, invalidation of speculatively written lines, clearing of the speculative read/write marks, the status write to the accumulator, clearing of the zero flag, and the restore. The restore takes one of two paths. For exceptions and interrupts, the faulting rIP is written to an exception-IP register and the handler is entered. For every other cause, fetch is redirected to the saved rIP. After the restore the controller leaves speculation and ignores abort triggers until the next region start.

Top module: `spec_abort_ctrl`

## Requirements
- R1: After reset the block is out of speculation, the zero flag is 0, and every strobe output (flush, status, invalidate, clear, accumulator write, restore, exception-IP write, redirect, handler entry) is low.
- R2: A region start sampled while the block is idle stores the next-rIP and rSP inputs as the checkpoint and raises in-speculation and the zero flag on the next cycle. A region start sampled while in speculation or during a rollback is ignored, and the checkpoint already held is kept.
- R3: In speculation, a sampling edge at which the oldest entry is valid with any of its four flags set, or the conflict interrupt is high, or the exception request is high, makes flush high in the following cycle. Flags on an entry whose valid bit is low do not start a rollback.
- R4: The rollback steps come one cycle each in this order: flush, status, invalidate, clear marks, accumulator write, zero-flag clear, restore. The zero flag stays 1 up to the zero-flag-clear cycle and is 0 from the restore cycle on.
- R5: Status codes are 1 contention (conflict flag or conflict interrupt), 2 explicit abort, 3 capacity, 4 disallowed operation, 5 far (exception or interrupt). When causes coincide, the priority is far > contention > capacity > disallowed > explicit.
- R6: For code 5, the restore cycle raises handler entry and the exception-IP write. The exception-IP value is the current rIP sampled at the triggering edge. The restored rIP and rSP equal the checkpoint, and redirect stays low.
- R7: For codes 1 to 4, the restore cycle raises redirect and drives the checkpoint rIP and rSP. Handler entry and the exception-IP write stay low.
- R8: In the cycle after the restore, in-speculation is low. From then until a new region start, abort triggers raise no flush.
- R9: In the status cycle the status code output equals the code, and in the accumulator-write cycle the accumulator data equals the code zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| region_start_i | input | 1 | Region start, captures the checkpoint |
| start_next_rip_i | input | XLEN | Address following the start instruction |
| start_rsp_i | input | XLEN | Stack pointer at region start |
| head_valid_i | input | 1 | Oldest reorder-buffer entry is valid |
| head_ovf_i | input | 1 | Oldest entry: capacity overflow flag |
| head_cnf_i | input | 1 | Oldest entry: conflict flag |
| head_abt_i | input | 1 | Oldest entry: explicit abort instruction |
| head_prh_i | input | 1 | Oldest entry: prohibited operation |
| conflict_irq_i | input | 1 | Immediate conflict interrupt |
| far_req_i | input | 1 | Exception or interrupt request |
| cur_rip_i | input | XLEN | Current rIP |
| flush_o | output | 1 | Pipeline flush step |
| status_valid_o | output | 1 | Status announcement step |
| status_code_o | output | 3 | Abort status code |
| spec_inval_o | output | 1 | Invalidate speculatively written lines |
| spec_bits_clr_o | output | 1 | Clear speculative read/write marks |
| rax_we_o | output | 1 | Accumulator write strobe |
| rax_data_o | output | XLEN | Accumulator write data |
| zf_o | output | 1 | Zero flag value |
| in_spec_o | output | 1 | Speculation or rollback in progress |
| restore_we_o | output | 1 | Restore rIP/rSP strobe |
| restore_rip_o | output | XLEN | Checkpoint rIP |
| restore_rsp_o | output | XLEN | Checkpoint rSP |
| eip_we_o | output | 1 | Exception-IP register write |
| eip_data_o | output | XLEN | Exception-IP value |
| redirect_o | output | 1 | Redirect fetch to checkpoint rIP |
| exc_enter_o | output | 1 | Enter exception handler |

## Verification
The hardest case to reach is a flagged entry that is not yet the oldest. The ports show it only as flags held while the valid bit is low. The stimulus holds all four flags with valid low for several cycles, then checks that no flush appears and that the region stays open. The priority cases are produced by vectors that raise several causes on the same edge, together with the exception request or the conflict interrupt. The test for an ignored nested start rewrites the checkpoint inputs in mid-region. It then checks, at the later restore, that the first values come back.

// File: rtl/spec_abort_pkg.sv
package spec_abort_pkg;

  typedef enum logic [2:0] {
    CODE_NONE = 3'd0,
    CODE_CONT = 3'd1,
    CODE_EXPL = 3'd2,
    CODE_CAP  = 3'd3,
    CODE_DIS  = 3'd4,
    CODE_FAR  = 3'd5
  } abort_code_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_SPEC  = 4'd1,
    ST_FLUSH = 4'd2,
    ST_STAT  = 4'd3,
    ST_INV   = 4'd4,
    ST_CLR   = 4'd5,
    ST_RAX   = 4'd6,
    ST_ZF    = 4'd7,
    ST_REST  = 4'd8
  } seq_state_e;

  // Priority: far > contention > capacity > disallowed > explicit.
  function automatic abort_code_e pick_code(
    input logic head_v, input logic ovf, input logic cnf,
    input logic abt, input logic prh, input logic irq, input logic far);
    logic hcnf, hovf, hprh, habt;
    hcnf = head_v & cnf;
    hovf = head_v & ovf;
    hprh = head_v & prh;
    habt = head_v & abt;
    if (far)              return CODE_FAR;
    else if (hcnf || irq) return CODE_CONT;
    else if (hovf)        return CODE_CAP;
    else if (hprh)        return CODE_DIS;
    else if (habt)        return CODE_EXPL;
    else                  return CODE_NONE;
  endfunction

  function automatic seq_state_e next_step(input seq_state_e s);
    case (s)
      ST_FLUSH: return ST_STAT;
      ST_STAT:  return ST_INV;
      ST_INV:   return ST_CLR;
      ST_CLR:   return ST_RAX;
      ST_RAX:   return ST_ZF;
      ST_ZF:    return ST_REST;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/spec_cause_sel.sv
module spec_cause_sel
  import spec_abort_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        head_valid_i,
  input  logic        head_ovf_i,
  input  logic        head_cnf_i,
  input  logic        head_abt_i,
  input  logic        head_prh_i,
  input  logic        conflict_irq_i,
  input  logic        far_req_i,
  output abort_code_e code_o,
  output logic        hit_o
);

  assign code_o = pick_code(head_valid_i, head_ovf_i, head_cnf_i,
                            head_abt_i, head_prh_i, conflict_irq_i, far_req_i);
  assign hit_o  = (code_o != CODE_NONE);

  AST_FAR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == CODE_FAR) |-> far_req_i); // R5
  AST_HEAD_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_valid_i && !conflict_irq_i && !far_req_i) |-> !hit_o); // R3

endmodule

// File: rtl/spec_shadow_ckpt.sv
module spec_shadow_ckpt #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [XLEN-1:0] rip_i,
  input  logic [XLEN-1:0] rsp_i,
  output logic [XLEN-1:0] rip_o,
  output logic [XLEN-1:0] rsp_o
);

  logic [XLEN-1:0] rip_q, rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rip_q <= '0;
      rsp_q <= '0;
    end else if (cap_i) begin
      rip_q <= rip_i;
      rsp_q <= rsp_i;
    end
  end

  assign rip_o = rip_q;
  assign rsp_o = rsp_q;

  AST_CKPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(rip_q) && $stable(rsp_q))); // R2

endmodule

// File: rtl/spec_rollback_seq.sv
module spec_rollback_seq
  import spec_abort_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            hit_i,
  input  abort_code_e     code_i,
  input  logic [XLEN-1:0] cur_rip_i,
  output seq_state_e      state_o,
  output logic            ckpt_cap_o,
  output logic            zf_o,
  output abort_code_e     code_o,
  output logic [XLEN-1:0] eip_o
);

  seq_state_e      st_q, st_d;
  logic            zf_q;
  abort_code_e     code_q;
  logic [XLEN-1:0] eip_q;
  logic            accept;

  assign ckpt_cap_o = start_i && (st_q == ST_IDLE);
  assign accept     = hit_i && (st_q == ST_SPEC);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_SPEC;
      ST_SPEC: if (hit_i)   st_d = ST_FLUSH;
      default:              st_d = next_step(st_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      zf_q   <= 1'b0;
      code_q <= CODE_NONE;
      eip_q  <= '0;
    end else begin
      st_q <= st_d;
      if (ckpt_cap_o)          zf_q <= 1'b1;
      else if (st_q == ST_ZF)  zf_q <= 1'b0;
      if (accept) begin
        code_q <= code_i;
        eip_q  <= cur_rip_i;
      end
    end
  end

  assign state_o = st_q;
  assign zf_o    = zf_q;
  assign code_o  = code_q;
  assign eip_o   = eip_q;

  AST_ABORT_STARTS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st_q == ST_FLUSH)); // R3
  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE)); // R8
  AST_ZF_UP_IN_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SPEC) |-> zf_q); // R2

endmodule

// File: rtl/spec_abort_ctrl.sv
module spec_abort_ctrl
  import spec_abort_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            region_start_i,
  input  logic [XLEN-1:0] start_next_rip_i,
  input  logic [XLEN-1:0] start_rsp_i,
  input  logic            head_valid_i,
  input  logic            head_ovf_i,
  input  logic            head_cnf_i,
  input  logic            head_abt_i,
  input  logic            head_prh_i,
  input  logic            conflict_irq_i,
  input  logic            far_req_i,
  input  logic [XLEN-1:0] cur_rip_i,
  output logic            flush_o,
  output logic            status_valid_o,
  output logic [2:0]      status_code_o,
  output logic            spec_inval_o,
  output logic            spec_bits_clr_o,
  output logic            rax_we_o,
  output logic [XLEN-1:0] rax_data_o,
  output logic            zf_o,
  output logic            in_spec_o,
  output logic            restore_we_o,
  output logic [XLEN-1:0] restore_rip_o,
  output logic [XLEN-1:0] restore_rsp_o,
  output logic            eip_we_o,
  output logic [XLEN-1:0] eip_data_o,
  output logic            redirect_o,
  output logic            exc_enter_o
);

  localparam int CODE_W = 3;
  localparam int PAD_W  = XLEN - CODE_W;

  abort_code_e     sel_code, held_code;
  logic            sel_hit, ckpt_cap, is_far;
  seq_state_e      state;

  spec_cause_sel u_cause (
    .clk            (clk),
    .rst_n          (rst_n),
    .head_valid_i   (head_valid_i),
    .head_ovf_i     (head_ovf_i),
    .head_cnf_i     (head_cnf_i),
    .head_abt_i     (head_abt_i),
    .head_prh_i     (head_prh_i),
    .conflict_irq_i (conflict_irq_i),
    .far_req_i      (far_req_i),
    .code_o         (sel_code),
    .hit_o          (sel_hit)
  );

  spec_rollback_seq #(.XLEN(XLEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (region_start_i),
    .hit_i      (sel_hit),
    .code_i     (sel_code),
    .cur_rip_i  (cur_rip_i),
    .state_o    (state),
    .ckpt_cap_o (ckpt_cap),
    .zf_o       (zf_o),
    .code_o     (held_code),
    .eip_o      (eip_data_o)
  );

  spec_shadow_ckpt #(.XLEN(XLEN)) u_ckpt (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (ckpt_cap),
    .rip_i (start_next_rip_i),
    .rsp_i (start_rsp_i),
    .rip_o (restore_rip_o),
    .rsp_o (restore_rsp_o)
  );

  assign is_far          = (held_code == CODE_FAR);
  assign flush_o         = (state == ST_FLUSH);
  assign status_valid_o  = (state == ST_STAT);
  assign status_code_o   = held_code;
  assign spec_inval_o    = (state == ST_INV);
  assign spec_bits_clr_o = (state == ST_CLR);
  assign rax_we_o        = (state == ST_RAX);
  assign rax_data_o      = {{PAD_W{1'b0}}, held_code};
  assign in_spec_o       = (state != ST_IDLE);
  assign restore_we_o    = (state == ST_REST);
  assign eip_we_o        = restore_we_o && is_far;
  assign exc_enter_o     = restore_we_o && is_far;
  assign redirect_o      = restore_we_o && !is_far;

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> status_valid_o); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_o, status_valid_o, spec_inval_o, spec_bits_clr_o,
              rax_we_o, restore_we_o})); // R4
  AST_ZF_LOW_AT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_we_o |-> !zf_o); // R4
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rax_we_o |-> (rax_data_o >= 1 && rax_data_o <= 5)); // R5
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    restore_we_o |-> (redirect_o ^ exc_enter_o)); // R6
  AST_EIP_ONLY_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    eip_we_o |-> (rax_data_o == XLEN'(5))); // R6
  AST_LEAVE_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    restore_we_o |=> !in_spec_o); // R8

endmodule

// File: tb/tb_spec_abort_ctrl.sv
module tb_spec_abort_ctrl;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            region_start_i = 1'b0;
  logic [XLEN-1:0] start_next_rip_i = '0, start_rsp_i = '0, cur_rip_i = '0;
  logic head_valid_i = 0, head_ovf_i = 0, head_cnf_i = 0, head_abt_i = 0, head_prh_i = 0;
  logic conflict_irq_i = 0, far_req_i = 0;
  logic flush_o, status_valid_o, spec_inval_o, spec_bits_clr_o, rax_we_o;
  logic [2:0] status_code_o;
  logic [XLEN-1:0] rax_data_o, restore_rip_o, restore_rsp_o, eip_data_o;
  logic zf_o, in_spec_o, restore_we_o, eip_we_o, redirect_o, exc_enter_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spec_abort_ctrl #(.XLEN(XLEN)) dut (.*);

  // Vector: {valid, ovf, cnf, abt, prh, irq, far, expected code[2:0]}
  localparam logic [9:0] VEC [11] = '{
    {7'b1100000, 3'd3},
    {7'b1010000, 3'd1},
    {7'b1001000, 3'd2},
    {7'b1000100, 3'd4},
    {7'b0000010, 3'd1},
    {7'b0000001, 3'd5},
    {7'b1101100, 3'd3},
    {7'b1001100, 3'd4},
    {7'b1110001, 3'd5},
    {7'b1001010, 3'd1},
    {7'b0111101, 3'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobes_low(input string req);
    chk({flush_o, status_valid_o, spec_inval_o, spec_bits_clr_o, rax_we_o,
         restore_we_o, eip_we_o, redirect_o, exc_enter_o} == 9'd0, req,
        {flush_o, status_valid_o, spec_inval_o, spec_bits_clr_o, rax_we_o,
         restore_we_o, eip_we_o, redirect_o, exc_enter_o}, 0);
  endtask

  task automatic open_region(input logic [XLEN-1:0] rip, input logic [XLEN-1:0] rsp);
    region_start_i = 1; start_next_rip_i = rip; start_rsp_i = rsp;
    tick();
    region_start_i = 0; start_next_rip_i = '0; start_rsp_i = '0;
    chk(in_spec_o === 1'b1, "R2 in_spec", in_spec_o, 1);
    chk(zf_o === 1'b1, "R2 zf set", zf_o, 1);
  endtask

  task automatic fire(input logic [6:0] f, input logic [XLEN-1:0] rip_now);
    {head_valid_i, head_ovf_i, head_cnf_i, head_abt_i, head_prh_i,
     conflict_irq_i, far_req_i} = f;
    cur_rip_i = rip_now;
    tick();
    {head_valid_i, head_ovf_i, head_cnf_i, head_abt_i, head_prh_i,
     conflict_irq_i, far_req_i} = '0;
    cur_rip_i = ~rip_now;
  endtask

  task automatic walk(input logic [2:0] code, input logic [XLEN-1:0] rip,
                      input logic [XLEN-1:0] rsp, input logic [XLEN-1:0] fault_rip);
    chk(flush_o === 1'b1, "R3 flush after trigger", flush_o, 1);
    tick();
    chk(status_valid_o === 1'b1 && status_code_o == code, "R5 R9 status code",
        {status_valid_o, status_code_o}, {1'b1, code});
    tick();
    chk(spec_inval_o === 1'b1, "R4 invalidate step", spec_inval_o, 1);
    tick();
    chk(spec_bits_clr_o === 1'b1, "R4 clear step", spec_bits_clr_o, 1);
    tick();
    chk(rax_we_o === 1'b1 && rax_data_o == XLEN'(code), "R9 rax write",
        rax_data_o, XLEN'(code));
    tick();
    chk(zf_o === 1'b1 && !restore_we_o, "R4 zf clear step", zf_o, 1);
    tick();
    chk(restore_we_o === 1'b1 && zf_o === 1'b0, "R4 restore zf low",
        {restore_we_o, zf_o}, 2'b10);
    chk(restore_rip_o == rip && restore_rsp_o == rsp, "R6 R7 restored rip/rsp",
        restore_rip_o, rip);
    if (code == 3'd5) begin
      chk(exc_enter_o && eip_we_o && !redirect_o, "R6 far path",
          {exc_enter_o, eip_we_o, redirect_o}, 3'b110);
      chk(eip_data_o == fault_rip, "R6 exception ip", eip_data_o, fault_rip);
    end else begin
      chk(redirect_o && !exc_enter_o && !eip_we_o, "R7 redirect path",
          {exc_enter_o, eip_we_o, redirect_o}, 3'b001);
    end
    tick();
    chk(in_spec_o === 1'b0, "R8 left speculation", in_spec_o, 0);
    strobes_low("R8 quiet after restore");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(in_spec_o === 1'b0 && zf_o === 1'b0, "R1 reset state", {in_spec_o, zf_o}, 0);
    strobes_low("R1 reset strobes");
    rst_n = 1;
    tick();

    for (int i = 0; i < 11; i++) begin
      logic [XLEN-1:0] rip, rsp, frip;
      rip  = 64'h4000_0000 + 64'(i * 16);
      rsp  = 64'h7fff_0000 - 64'(i * 8);
      frip = 64'h1234_0000 + 64'(i);
      open_region(rip, rsp);
      tick();
      fire(VEC[i][9:3], frip);
      walk(VEC[i][2:0], rip, rsp, frip);
      tick();
    end

    // R3: flags on a non-oldest (invalid) head do not abort
    open_region(64'hAAAA_0000, 64'hBBBB_0000);
    head_valid_i = 0; head_ovf_i = 1; head_cnf_i = 1; head_abt_i = 1; head_prh_i = 1;
    repeat (4) begin
      tick();
      chk(flush_o === 1'b0 && in_spec_o === 1'b1, "R3 invalid head ignored",
          {flush_o, in_spec_o}, 2'b01);
    end
    {head_ovf_i, head_cnf_i, head_abt_i, head_prh_i} = '0;
    // R2: nested start ignored, checkpoint kept
    region_start_i = 1; start_next_rip_i = 64'hDEAD; start_rsp_i = 64'hBEEF;
    tick();
    region_start_i = 0;
    chk(flush_o === 1'b0 && in_spec_o === 1'b1, "R2 nested start no effect",
        {flush_o, in_spec_o}, 2'b01);
    fire(7'b1001000, 64'h55);
    walk(3'd2, 64'hAAAA_0000, 64'hBBBB_0000, 64'h55);

    // R8: triggers after rollback ignored
    head_valid_i = 1; head_cnf_i = 1; conflict_irq_i = 1; far_req_i = 1;
    repeat (3) begin
      tick();
      chk(flush_o === 1'b0 && in_spec_o === 1'b0, "R8 idle ignores triggers",
          {flush_o, in_spec_o}, 0);
    end
    head_valid_i = 0; head_cnf_i = 0; conflict_irq_i = 0; far_req_i = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule